// File: doc/BRIEF.md
# Keyed Configuration Port

This block is a two-address configuration port. It decodes an index port and a data port on a narrow bus: the index port is at a base address and the data port is at the next address. Configuration space stays locked after reset. Software opens it by writing a fixed opening key byte to the index port twice in a row. While the port is open, a byte written to the index port selects a register, and accesses to the data port read or write that register. A separate closing key written to the index port locks the port again.

Register indices below 0x30 are global. The global set holds a device-select register and read-only identification bytes. Indices from 0x30 upward are banked, so each logical device has its own copy, and the device-select value picks which copy the data port reaches. Each bank is a plain register array. Bit 0 of the first banked register drives an enable output for that device. A strap input chooses the base address. The strap is captured during reset, so the decode window cannot move while the system runs.

Top module: `cfgp_top`

## Requirements
- R1: The index port is at the base address and the data port is at the base address plus 1. The base address is 0x2E when `strap_alt` is low during reset and 0x4E when it is high. A change of `strap_alt` after reset has no effect on the decode.
- R2: After reset the port is locked. While locked, a read of either port returns 0xFF and a write to the data port has no effect.
- R3: Two successive writes of 0x87 to the index port open the port. Any other write to either port between the two key bytes restarts key detection. Reads do not affect key detection.
- R4: While open, a write of 0xAA to the index port locks the port and leaves the index latch unchanged. Any other index write, including 0x87, is latched as the new index.
- R5: While open, a read of the index port returns the latched index. The index is 0x00 after reset.
- R6: Global index 0x07 is a read/write device-select register that keeps all 8 bits.
- R7: Global indices 0x20 and 0x21 return the high and low bytes of the 16-bit device ID (default 0x5A3C). Index 0x22 returns the revision byte (default 0x07). Indices 0x23 and 0x24 return the high and low bytes of the 16-bit vendor ID (default 0xC0DE). Writes to these indices are ignored. All other global indices below 0x30 except 0x07 read 0x00 and ignore writes.
- R8: Indices 0x30 to 0x30+BANK_REGS-1 (0x3F by default) reach the bank of the selected device, and each device keeps its own values. When the device select is NUM_DEV (8) or above, or the index is past the bank window, data reads return 0x00 and data writes have no effect.
- R9: `dev_enable[d]` equals bit 0 of banked index 0x30 of device d. It changes on the clock edge that completes the write. It is 0 after reset and does not change while the port is locked.
- R10: An access to any address other than the two ports reads 0xFF and has no effect, including on key detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the strap |
| strap_alt | input | 1 | Base address select: 0 gives 0x2E, 1 gives 0x4E |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (16) | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the current access; 0xFF when there is no port read |
| dev_enable | output | NUM_DEV (8) | Per-device enable bits |

## Verification
Every index-port write is seen in the same cycle by the key detector and by the index latch, so one byte can be both a key and an index. The bench provokes both cases. It writes 0x87 while the port is open and then reads the index port, expecting 0x87. It sets the index to 0x33 and writes 0xAA. The port must then read 0xFF at once, and after a fresh unlock the index must read back 0x33. Stray data-port writes and writes at a foreign address are placed between the two key bytes. Each case is judged by whether the next index read returns 0xFF or the latched index.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam logic [7:0] KEY_OPEN      = 8'h87;
    localparam logic [7:0] KEY_CLOSE     = 8'hAA;
    localparam logic [7:0] IDX_DEVSEL    = 8'h07;
    localparam logic [7:0] IDX_DEVID_HI  = 8'h20;
    localparam logic [7:0] IDX_DEVID_LO  = 8'h21;
    localparam logic [7:0] IDX_REVISION  = 8'h22;
    localparam logic [7:0] IDX_VENID_HI  = 8'h23;
    localparam logic [7:0] IDX_VENID_LO  = 8'h24;
    localparam logic [7:0] IDX_BANK_BASE = 8'h30;
    localparam logic [7:0] RD_IDLE       = 8'hFF;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    // one decoded write event on the port pair
    typedef struct packed {
        logic       to_idx;
        logic       to_dat;
        logic [7:0] data;
    } port_wr_t;

    function automatic logic is_global(input logic [7:0] idx);
        return idx < IDX_BANK_BASE;
    endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = ADDR_W'('h2E),
    parameter logic [ADDR_W-1:0] BASE_ALT = ADDR_W'('h4E)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_alt,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output port_wr_t          wr_ev,
    output logic              idx_rd,
    output logic              dat_rd,
    output logic [ADDR_W-1:0] base_q
);
    logic hit_idx;
    logic hit_dat;

    // strap is captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= strap_alt ? BASE_ALT : BASE_PRI;
        end
    end

    always_comb begin
        hit_idx      = bus_valid && (bus_addr == base_q);
        hit_dat      = bus_valid && (bus_addr == base_q + ADDR_W'(1));
        wr_ev.to_idx = hit_idx && bus_write;
        wr_ev.to_dat = hit_dat && bus_write;
        wr_ev.data   = bus_wdata;
        idx_rd       = hit_idx && !bus_write;
        dat_rd       = hit_dat && !bus_write;
    end
endmodule

// File: rtl/cfgp_keyfsm.sv
module cfgp_keyfsm
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_wr_t   wr_ev,
    output key_state_e state_q,
    output logic       cfg_open
);
    key_state_e state_d;
    logic       key_hit;
    logic       any_wr;

    always_comb begin
        key_hit = wr_ev.to_idx && (wr_ev.data == KEY_OPEN);
        any_wr  = wr_ev.to_idx || wr_ev.to_dat;
        state_d = state_q;
        unique case (state_q)
            KS_LOCKED: if (key_hit) state_d = KS_HALF;
            KS_HALF: begin
                if (key_hit)     state_d = KS_OPEN;
                else if (any_wr) state_d = KS_LOCKED;
            end
            KS_OPEN: begin
                if (wr_ev.to_idx && (wr_ev.data == KEY_CLOSE))
                    state_d = KS_LOCKED;
            end
            default: state_d = KS_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_LOCKED;
        else     state_q <= state_d;
    end

    assign cfg_open = (state_q == KS_OPEN);
endmodule

// File: rtl/cfgp_global.sv
module cfgp_global
    import cfgp_pkg::*;
#(
    parameter logic [15:0] DEV_ID  = 16'h5A3C,
    parameter logic [15:0] VEN_ID  = 16'hC0DE,
    parameter logic [7:0]  REV_ID  = 8'h07
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dat_we,
    input  logic [7:0] idx_q,
    input  logic [7:0] wdata,
    output logic [7:0] devsel_q,
    output logic [7:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            devsel_q <= 8'h00;
        end else if (dat_we && (idx_q == IDX_DEVSEL)) begin
            devsel_q <= wdata;
        end
    end

    always_comb begin
        unique case (idx_q)
            IDX_DEVSEL:   rdata = devsel_q;
            IDX_DEVID_HI: rdata = DEV_ID[15:8];
            IDX_DEVID_LO: rdata = DEV_ID[7:0];
            IDX_REVISION: rdata = REV_ID;
            IDX_VENID_HI: rdata = VEN_ID[15:8];
            IDX_VENID_LO: rdata = VEN_ID[7:0];
            default:      rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank #(
    parameter int NUM_DEV   = 8,
    parameter int BANK_REGS = 16,
    localparam int SEL_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int OFS_W    = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SEL_W-1:0]   dev_sel,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic [NUM_DEV-1:0] dev_enable
);
    logic [7:0] dev_rd [NUM_DEV];

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [7:0] regs_q [BANK_REGS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int r = 0; r < BANK_REGS; r++) regs_q[r] <= 8'h00;
            end else if (we && (dev_sel == SEL_W'(d))) begin
                regs_q[ofs] <= wdata;
            end
        end

        assign dev_rd[d]     = regs_q[ofs];
        assign dev_enable[d] = regs_q[0][0];
    end

    assign rdata = dev_rd[dev_sel];
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI  = ADDR_W'('h2E),
    parameter logic [ADDR_W-1:0] BASE_ALT  = ADDR_W'('h4E),
    parameter int                NUM_DEV   = 8,
    parameter int                BANK_REGS = 16,
    parameter logic [15:0]       DEV_ID    = 16'h5A3C,
    parameter logic [15:0]       VEN_ID    = 16'hC0DE,
    parameter logic [7:0]        REV_ID    = 8'h07
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strap_alt,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic [NUM_DEV-1:0] dev_enable
);
    localparam int SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int OFS_W   = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;
    localparam int WIN_END = int'(IDX_BANK_BASE) + BANK_REGS;

    port_wr_t          wr_ev;
    logic              idx_rd;
    logic              dat_rd;
    logic [ADDR_W-1:0] base_q;
    key_state_e        key_state;
    logic              cfg_open;
    logic [7:0]        idx_q;
    logic [7:0]        devsel_q;
    logic [7:0]        glob_rd;
    logic [7:0]        bank_rd;
    logic              dat_we;
    logic              in_window;
    logic              sel_ok;
    logic              bank_we;

    cfgp_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_PRI (BASE_PRI),
        .BASE_ALT (BASE_ALT)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .strap_alt (strap_alt),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_ev     (wr_ev),
        .idx_rd    (idx_rd),
        .dat_rd    (dat_rd),
        .base_q    (base_q)
    );

    cfgp_keyfsm u_keyfsm (
        .clk      (clk),
        .rst      (rst),
        .wr_ev    (wr_ev),
        .state_q  (key_state),
        .cfg_open (cfg_open)
    );

    // index latch: only while open, and the closing key is not an index
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= 8'h00;
        end else if (cfg_open && wr_ev.to_idx && (wr_ev.data != KEY_CLOSE)) begin
            idx_q <= wr_ev.data;
        end
    end

    always_comb begin
        dat_we    = cfg_open && wr_ev.to_dat;
        in_window = !is_global(idx_q) && (int'(idx_q) < WIN_END);
        sel_ok    = int'(devsel_q) < NUM_DEV;
        bank_we   = dat_we && in_window && sel_ok;
    end

    cfgp_global #(
        .DEV_ID (DEV_ID),
        .VEN_ID (VEN_ID),
        .REV_ID (REV_ID)
    ) u_global (
        .clk      (clk),
        .rst      (rst),
        .dat_we   (dat_we),
        .idx_q    (idx_q),
        .wdata    (wr_ev.data),
        .devsel_q (devsel_q),
        .rdata    (glob_rd)
    );

    cfgp_bank #(
        .NUM_DEV   (NUM_DEV),
        .BANK_REGS (BANK_REGS)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .we         (bank_we),
        .dev_sel    (SEL_W'(devsel_q)),
        .ofs        (OFS_W'(idx_q - IDX_BANK_BASE)),
        .wdata      (wr_ev.data),
        .rdata      (bank_rd),
        .dev_enable (dev_enable)
    );

    always_comb begin
        bus_rdata = RD_IDLE;
        if (cfg_open) begin
            if (idx_rd) begin
                bus_rdata = idx_q;
            end else if (dat_rd) begin
                if (is_global(idx_q))          bus_rdata = glob_rd;
                else if (in_window && sel_ok)  bus_rdata = bank_rd;
                else                           bus_rdata = 8'h00;
            end
        end
    end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_DEV = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic [NUM_DEV-1:0] dev_enable,
    input key_state_e         state_q,
    input logic [ADDR_W-1:0]  base_q
);
    logic at_idx;
    logic at_dat;
    logic foreign;

    assign at_idx  = bus_valid && (bus_addr == base_q);
    assign at_dat  = bus_valid && (bus_addr == base_q + ADDR_W'(1));
    assign foreign = bus_valid && !at_idx && !at_dat;

    p_base_fixed_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(base_q));

    p_locked_reads_ff_r2: assert property (@(posedge clk) disable iff (rst)
        ((at_idx || at_dat) && !bus_write && state_q != KS_OPEN) |-> bus_rdata == 8'hFF);

    p_second_key_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_HALF && at_idx && bus_write && bus_wdata == 8'h87) |=> state_q == KS_OPEN);

    p_stray_write_restarts_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_HALF && (at_idx || at_dat) && bus_write
         && !(at_idx && bus_wdata == 8'h87)) |=> state_q == KS_LOCKED);

    p_close_key_locks_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_OPEN && at_idx && bus_write && bus_wdata == 8'hAA) |=> state_q == KS_LOCKED);

    p_locked_enable_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q != KS_OPEN) |=> $stable(dev_enable));

    p_foreign_read_ff_r10: assert property (@(posedge clk) disable iff (rst)
        (foreign && !bus_write) |-> bus_rdata == 8'hFF);

    p_foreign_write_inert_r10: assert property (@(posedge clk) disable iff (rst)
        (foreign && bus_write) |=> $stable(state_q));
endmodule

bind cfgp_top cfgp_checker #(
    .ADDR_W  (ADDR_W),
    .NUM_DEV (NUM_DEV)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .dev_enable (dev_enable),
    .state_q    (key_state),
    .base_q     (base_q)
);

// File: tb/tb_cfgp_top.sv
`timescale 1ns/1ps
module tb_cfgp_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_alt = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr  = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  dev_enable;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cfgp_top dut (
        .clk        (clk),
        .rst        (rst),
        .strap_alt  (strap_alt),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dev_enable (dev_enable)
    );

    // vector: {req[3:0], write, addr[15:0], data[7:0]}; data is the
    // write byte for writes and the expected read byte for reads
    localparam int NV = 63;
    localparam logic [28:0] VEC [NV] = '{
        {4'd2, 1'b0, 16'h002E, 8'hFF},  // R2 locked index read
        {4'd2, 1'b0, 16'h002F, 8'hFF},  // R2 locked data read
        {4'd2, 1'b1, 16'h002F, 8'h55},  // R2 locked data write ignored
        {4'd3, 1'b1, 16'h002E, 8'h87},  // R3 first key
        {4'd3, 1'b1, 16'h002E, 8'h12},  // R3 stray index write restarts
        {4'd3, 1'b1, 16'h002E, 8'h87},  // R3 first key again
        {4'd3, 1'b0, 16'h002E, 8'hFF},  // R3 still locked, read harmless
        {4'd3, 1'b1, 16'h002F, 8'h87},  // R3 data write restarts
        {4'd3, 1'b1, 16'h002E, 8'h87},  // R3 first key
        {4'd3, 1'b0, 16'h002F, 8'hFF},  // R3 still locked
        {4'd10, 1'b1, 16'h004E, 8'h87}, // R10 foreign address write
        {4'd3, 1'b1, 16'h002E, 8'h87},  // R3 second key opens
        {4'd5, 1'b0, 16'h002E, 8'h00},  // R5 index reset value
        {4'd7, 1'b1, 16'h002E, 8'h20},  // R7
        {4'd7, 1'b0, 16'h002F, 8'h5A},
        {4'd7, 1'b1, 16'h002E, 8'h21},
        {4'd7, 1'b0, 16'h002F, 8'h3C},
        {4'd7, 1'b1, 16'h002E, 8'h22},
        {4'd7, 1'b0, 16'h002F, 8'h07},
        {4'd7, 1'b1, 16'h002E, 8'h23},
        {4'd7, 1'b0, 16'h002F, 8'hC0},
        {4'd7, 1'b1, 16'h002E, 8'h24},
        {4'd7, 1'b0, 16'h002F, 8'hDE},
        {4'd7, 1'b1, 16'h002F, 8'h99},  // R7 write to read-only id
        {4'd7, 1'b0, 16'h002F, 8'hDE},
        {4'd7, 1'b1, 16'h002E, 8'h10},  // R7 unused global
        {4'd7, 1'b1, 16'h002F, 8'h44},
        {4'd7, 1'b0, 16'h002F, 8'h00},
        {4'd6, 1'b1, 16'h002E, 8'h07},  // R6 device select
        {4'd6, 1'b1, 16'h002F, 8'h03},
        {4'd6, 1'b0, 16'h002F, 8'h03},
        {4'd5, 1'b0, 16'h002E, 8'h07},  // R5 index readback
        {4'd8, 1'b1, 16'h002E, 8'h35},  // R8 banked write dev 3
        {4'd8, 1'b1, 16'h002F, 8'hA5},
        {4'd8, 1'b0, 16'h002F, 8'hA5},
        {4'd8, 1'b1, 16'h002E, 8'h07},  // R8 switch to dev 4
        {4'd8, 1'b1, 16'h002F, 8'h04},
        {4'd8, 1'b1, 16'h002E, 8'h35},
        {4'd8, 1'b0, 16'h002F, 8'h00},  // R8 dev 4 separate
        {4'd6, 1'b1, 16'h002E, 8'h07},  // R6 select out of range
        {4'd6, 1'b1, 16'h002F, 8'h08},
        {4'd6, 1'b0, 16'h002F, 8'h08},
        {4'd8, 1'b1, 16'h002E, 8'h35},
        {4'd8, 1'b1, 16'h002F, 8'h77},  // R8 no device
        {4'd8, 1'b0, 16'h002F, 8'h00},
        {4'd8, 1'b1, 16'h002E, 8'h40},  // R8 past window
        {4'd8, 1'b1, 16'h002F, 8'h66},
        {4'd8, 1'b0, 16'h002F, 8'h00},
        {4'd4, 1'b1, 16'h002E, 8'h87},  // R4 open key latched as index
        {4'd4, 1'b0, 16'h002E, 8'h87},
        {4'd4, 1'b1, 16'h002E, 8'h33},
        {4'd4, 1'b1, 16'h002E, 8'hAA},  // R4 close
        {4'd4, 1'b0, 16'h002F, 8'hFF},
        {4'd4, 1'b0, 16'h002E, 8'hFF},
        {4'd4, 1'b1, 16'h002E, 8'h87},
        {4'd4, 1'b1, 16'h002E, 8'h87},
        {4'd4, 1'b0, 16'h002E, 8'h33},  // R4 index kept through lock
        {4'd8, 1'b1, 16'h002E, 8'h07},  // R8 back to dev 3
        {4'd8, 1'b1, 16'h002F, 8'h03},
        {4'd8, 1'b1, 16'h002E, 8'h35},
        {4'd8, 1'b0, 16'h002F, 8'hA5},
        {4'd10, 1'b0, 16'h0000, 8'hFF}, // R10 foreign read
        {4'd10, 1'b1, 16'h002E, 8'hAA}  // close again
    };

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = 8'h00;
        #1;
        check8(bus_rdata, exp, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check8(dev_enable, 8'h00, "R9 reset enables");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_valid = 1'b1;
            bus_write = VEC[i][24];
            bus_addr  = VEC[i][23:8];
            bus_wdata = VEC[i][24] ? VEC[i][7:0] : 8'h00;
            #1;
            if (!VEC[i][24]) begin
                n_vec++;
                if (bus_rdata !== VEC[i][7:0]) begin
                    n_miss++;
                    $display("FAIL R%0d vector %0d actual=%02h expected=%02h",
                             VEC[i][28:25], i, bus_rdata, VEC[i][7:0]);
                end
            end
        end
        idle();

        // R9: enable bit of device 2
        wr(16'h002E, 8'h87);
        wr(16'h002E, 8'h87);
        wr(16'h002E, 8'h07);
        wr(16'h002F, 8'h02);
        wr(16'h002E, 8'h30);
        wr(16'h002F, 8'h01);
        idle();
        check8(dev_enable, 8'h04, "R9 enable set");
        wr(16'h002E, 8'hAA);
        wr(16'h002F, 8'h00);
        idle();
        check8(dev_enable, 8'h04, "R9 enable held while locked");

        // R1: strap high selects 0x4E, captured in reset
        @(negedge clk);
        rst = 1'b1; strap_alt = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check8(dev_enable, 8'h00, "R9 enables cleared by reset");
        strap_alt = 1'b0;
        rd(16'h002E, 8'hFF, "R1 old base not decoded");
        wr(16'h002E, 8'h87);
        wr(16'h002E, 8'h87);
        rd(16'h002E, 8'hFF, "R1 keys at old base ignored");
        wr(16'h004E, 8'h87);
        wr(16'h004E, 8'h87);
        rd(16'h004E, 8'h00, "R1 alternate base opens");
        wr(16'h004E, 8'h22);
        rd(16'h004F, 8'h07, "R1 alternate data port");
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule